// File: doc/BRIEF.md
# Two-Link Skew-Absorbing Pixel Merger

This block receives two serial-to-parallel video links. Each link has its own recovered pixel clock, a 24-bit pixel bus and three qualifiers: frame active, line active and word strobe. One static mode input selects between two ways of using the links.

- **Dual-camera mode.** The links are unrelated. Each link drains to its own output channel in the system clock domain, and each channel has its own valid.
- **Fused mode.** The two links carry the halves of one wide camera, such as a four-tap 12-bit sensor, and their words are joined into one 48-bit word per pixel time.

The two cables can arrive with different delays. Each link therefore writes into its own dual-clock FIFO. The words are tagged on the link side when they are the first strobed word after line-active goes high. In fused mode the reader discards words until both FIFO heads show that tag. From then on it pops both FIFOs together.

If the pair it pops disagrees in line-active or frame-active, the reader flags an error. It then falls back to hunting for the next line start. A FIFO that is full drops the incoming word and raises a sticky overflow flag.

Top module: `dlm_dual_link`

## Requirements
- R1: With `fused_mode`=0, every strobed word of link 0 appears on `ch0_*`, and every strobed word of link 1 appears on `ch1_*`. Each appears exactly once, in arrival order, with `chN_valid` high for one system clock per word.
- R2: With `fused_mode`=1, `ch0_valid` and `ch1_valid` stay low. With `fused_mode`=0, `m_valid` stays low.
- R3: A fused output word carries link 0's pixel in `m_data[23:0]` and link 1's pixel in `m_data[47:24]`. `m_lv` and `m_fv` are the common qualifiers of the pair.
- R4: In fused mode, until alignment is reached, each link discards its words that precede its first line-start word. A line-start word is a strobed word with line-active high whose link saw line-active low on some clock since its previous strobed word. The first merged word pairs the two line-start words.
- R5: Once aligned, each merged word consumes exactly one word from each link, in order, so the k-th words of a line are paired regardless of link clock rates or skew.
- R6: If a popped pair differs in line-active or frame-active, the following happens. The pair produces no output. `align_err` becomes 1 and stays 1 until reset. No merged word appears until both links present a line-start word, and those two words are then paired.
- R7: A word strobed into a full link FIFO (depth 2**FIFO_AW, 8 by default) is dropped, and stored words are kept. The link's flag (`ovf0` or `ovf1`) then becomes 1 and stays 1 until reset. The other link's flag is unaffected.
- R8: While `rst` is high and after it falls, with no strobes, all valids, `align_err`, `ovf0` and `ovf1` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Common read-side clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of all three clocks |
| fused_mode | input | 1 | 1 = join links into one wide stream, 0 = two cameras; change only under reset |
| lnk0_clk | input | 1 | Recovered pixel clock of link 0 |
| lnk0_data | input | 24 | Link 0 pixel bits |
| lnk0_fv | input | 1 | Link 0 frame active |
| lnk0_lv | input | 1 | Link 0 line active |
| lnk0_dv | input | 1 | Link 0 word strobe |
| lnk1_clk | input | 1 | Recovered pixel clock of link 1 |
| lnk1_data | input | 24 | Link 1 pixel bits |
| lnk1_fv | input | 1 | Link 1 frame active |
| lnk1_lv | input | 1 | Link 1 line active |
| lnk1_dv | input | 1 | Link 1 word strobe |
| m_valid | output | 1 | Fused word valid |
| m_data | output | 48 | Fused word, link 1 high half |
| m_fv | output | 1 | Fused word frame active |
| m_lv | output | 1 | Fused word line active |
| ch0_valid | output | 1 | Dual mode channel 0 valid |
| ch0_data | output | 24 | Dual mode channel 0 pixel |
| ch0_fv | output | 1 | Channel 0 frame active |
| ch0_lv | output | 1 | Channel 0 line active |
| ch1_valid | output | 1 | Dual mode channel 1 valid |
| ch1_data | output | 24 | Dual mode channel 1 pixel |
| ch1_fv | output | 1 | Channel 1 frame active |
| ch1_lv | output | 1 | Channel 1 line active |
| align_err | output | 1 | Sticky pair-mismatch flag |
| ovf0 | output | 1 | Sticky link 0 overflow flag |
| ovf1 | output | 1 | Sticky link 1 overflow flag |

## Verification
A reader that never locks, or locks one word off, shows up within one line. Either no fused words appear, or every 48-bit word carries halves from different pixel positions. A pointer that wraps or overwrites on a full FIFO shows up as a repeated or missing pixel in the next words read after the link drains. A mismatch that fails to discard shows up immediately as an extra fused word. A dropped error shows up as `align_err` falling low.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

    localparam int LANE_W = 24;

    // one stored link word: tag, qualifiers, pixel bits
    typedef struct packed {
        logic              sol;
        logic              fv;
        logic              lv;
        logic [LANE_W-1:0] pix;
    } lane_word_t;

    localparam int WORD_W = $bits(lane_word_t);

    function automatic logic [7:0] to_gray8(input logic [7:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/dlm_sync.sv
module dlm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dlm_link_tag.sv
module dlm_link_tag
    import dlm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] data,
    input  logic              fv,
    input  logic              lv,
    input  logic              dv,
    output logic              wr_en,
    output lane_word_t        word
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst)      armed <= 1'b1;
        else if (!lv) armed <= 1'b1;
        else if (dv)  armed <= 1'b0;
    end

    assign wr_en     = dv;
    assign word.sol  = dv && lv && armed;
    assign word.fv   = fv;
    assign word.lv   = lv;
    assign word.pix  = data;
endmodule

// File: rtl/dlm_async_fifo.sv
module dlm_async_fifo
    import dlm_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic       wclk,
    input  logic       rst,
    input  logic       wr_en,
    input  lane_word_t wdata,
    input  logic       rclk,
    input  logic       rd_en,
    output lane_word_t rdata,
    output logic       empty,
    output logic       ovf_r
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;
    localparam logic [PW-1:0] ONE = {{AW{1'b0}}, 1'b1};

    lane_word_t mem [DEPTH];

    logic [PW-1:0] wbin, wgray, rbin, rgray, rgray_w, wgray_r;
    logic [PW-1:0] wbin_n, rbin_n;
    logic          full, ovf_w;

    // ---- write domain ----
    dlm_sync #(.W(PW)) u_rsync (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_w));

    assign wbin_n = wbin + ONE;
    assign full   = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
            ovf_w <= 1'b0;
        end else if (wr_en) begin
            if (full) begin
                ovf_w <= 1'b1;
            end else begin
                wbin  <= wbin_n;
                wgray <= wbin_n ^ (wbin_n >> 1);
            end
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_en && !full) mem[wbin[AW-1:0]] <= wdata;
    end

    // ---- read domain ----
    dlm_sync #(.W(PW)) u_wsync (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_r));
    dlm_sync #(.W(1))  u_osync (.clk(rclk), .rst(rst), .d(ovf_w), .q(ovf_r));

    assign rbin_n = rbin + ONE;
    assign empty  = (rgray == wgray_r);
    assign rdata  = mem[rbin[AW-1:0]];

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_en && !empty) begin
            rbin  <= rbin_n;
            rgray <= rbin_n ^ (rbin_n >> 1);
        end
    end

    assert_full_drop_R7: assert property (@(posedge wclk) disable iff (rst)
        (wr_en && full) |=> $stable(wbin));
    assert_ovf_sticky_R7: assert property (@(posedge wclk) disable iff (rst)
        ovf_w |=> ovf_w);
    assert_pop_nonempty_R5: assert property (@(posedge rclk) disable iff (rst)
        rd_en |-> !empty);
endmodule

// File: rtl/dlm_merge_ctrl.sv
module dlm_merge_ctrl
    import dlm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fused,
    input  logic                emp0,
    input  logic                emp1,
    input  lane_word_t          head0,
    input  lane_word_t          head1,
    output logic                pop0,
    output logic                pop1,
    output logic                m_valid,
    output logic [2*LANE_W-1:0] m_data,
    output logic                m_fv,
    output logic                m_lv,
    output logic                c0_valid,
    output lane_word_t          c0_word,
    output logic                c1_valid,
    output lane_word_t          c1_word,
    output logic                err
);
    logic aligned, aligned_n, take_pair, err_set;

    always_comb begin
        pop0      = 1'b0;
        pop1      = 1'b0;
        take_pair = 1'b0;
        err_set   = 1'b0;
        aligned_n = aligned;
        if (!fused) begin
            pop0      = !emp0;
            pop1      = !emp1;
            aligned_n = 1'b0;
        end else if (!aligned) begin
            if (!emp0 && !head0.sol) pop0 = 1'b1;
            if (!emp1 && !head1.sol) pop1 = 1'b1;
            if (!emp0 && !emp1 && head0.sol && head1.sol) begin
                pop0      = 1'b1;
                pop1      = 1'b1;
                take_pair = 1'b1;
                aligned_n = 1'b1;
            end
        end else if (!emp0 && !emp1) begin
            pop0 = 1'b1;
            pop1 = 1'b1;
            if ((head0.lv != head1.lv) || (head0.fv != head1.fv)) begin
                err_set   = 1'b1;
                aligned_n = 1'b0;
            end else begin
                take_pair = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aligned  <= 1'b0;
            err      <= 1'b0;
            m_valid  <= 1'b0;
            m_data   <= '0;
            m_fv     <= 1'b0;
            m_lv     <= 1'b0;
            c0_valid <= 1'b0;
            c1_valid <= 1'b0;
            c0_word  <= '0;
            c1_word  <= '0;
        end else begin
            aligned  <= aligned_n;
            err      <= err | err_set;
            m_valid  <= take_pair;
            m_data   <= {head1.pix, head0.pix};
            m_fv     <= head0.fv;
            m_lv     <= head0.lv;
            c0_valid <= !fused && pop0;
            c1_valid <= !fused && pop1;
            c0_word  <= head0;
            c1_word  <= head1;
        end
    end

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    assert_dual_no_merge_R2: assert property (@(posedge clk) disable iff (rst)
        !fused |=> !m_valid);
    assert_fused_no_chan_R2: assert property (@(posedge clk) disable iff (rst)
        fused |=> (!c0_valid && !c1_valid));
    assert_lockstep_pop_R5: assert property (@(posedge clk) disable iff (rst)
        (fused && aligned && pop0) |-> pop1);
    assert_lock_on_sol_R4: assert property (@(posedge clk) disable iff (rst)
        (fused && !aligned && aligned_n) |-> (head0.sol && head1.sol));
endmodule

// File: rtl/dlm_dual_link.sv
module dlm_dual_link
    import dlm_pkg::*;
#(
    parameter int FIFO_AW = 3
) (
    input  logic          sys_clk,
    input  logic          rst,
    input  logic          fused_mode,
    input  logic          lnk0_clk,
    input  logic [23:0]   lnk0_data,
    input  logic          lnk0_fv,
    input  logic          lnk0_lv,
    input  logic          lnk0_dv,
    input  logic          lnk1_clk,
    input  logic [23:0]   lnk1_data,
    input  logic          lnk1_fv,
    input  logic          lnk1_lv,
    input  logic          lnk1_dv,
    output logic          m_valid,
    output logic [47:0]   m_data,
    output logic          m_fv,
    output logic          m_lv,
    output logic          ch0_valid,
    output logic [23:0]   ch0_data,
    output logic          ch0_fv,
    output logic          ch0_lv,
    output logic          ch1_valid,
    output logic [23:0]   ch1_data,
    output logic          ch1_fv,
    output logic          ch1_lv,
    output logic          align_err,
    output logic          ovf0,
    output logic          ovf1
);
    localparam int NL = 2;

    logic [NL-1:0]     l_clk, l_fv, l_lv, l_dv, l_wr, l_emp, l_pop, l_ovf;
    logic [LANE_W-1:0] l_data [NL];
    lane_word_t        l_word [NL];
    lane_word_t        l_head [NL];
    lane_word_t        c0_w, c1_w;

    assign l_clk     = {lnk1_clk, lnk0_clk};
    assign l_fv      = {lnk1_fv, lnk0_fv};
    assign l_lv      = {lnk1_lv, lnk0_lv};
    assign l_dv      = {lnk1_dv, lnk0_dv};
    assign l_data[0] = lnk0_data;
    assign l_data[1] = lnk1_data;

    for (genvar i = 0; i < NL; i++) begin : g_link
        dlm_link_tag u_tag (
            .clk(l_clk[i]), .rst(rst), .data(l_data[i]),
            .fv(l_fv[i]), .lv(l_lv[i]), .dv(l_dv[i]),
            .wr_en(l_wr[i]), .word(l_word[i])
        );
        dlm_async_fifo #(.AW(FIFO_AW)) u_fifo (
            .wclk(l_clk[i]), .rst(rst), .wr_en(l_wr[i]), .wdata(l_word[i]),
            .rclk(sys_clk), .rd_en(l_pop[i]), .rdata(l_head[i]),
            .empty(l_emp[i]), .ovf_r(l_ovf[i])
        );
    end

    dlm_merge_ctrl u_merge (
        .clk(sys_clk), .rst(rst), .fused(fused_mode),
        .emp0(l_emp[0]), .emp1(l_emp[1]),
        .head0(l_head[0]), .head1(l_head[1]),
        .pop0(l_pop[0]), .pop1(l_pop[1]),
        .m_valid(m_valid), .m_data(m_data), .m_fv(m_fv), .m_lv(m_lv),
        .c0_valid(ch0_valid), .c0_word(c0_w),
        .c1_valid(ch1_valid), .c1_word(c1_w),
        .err(align_err)
    );

    assign ch0_data = c0_w.pix;
    assign ch0_fv   = c0_w.fv;
    assign ch0_lv   = c0_w.lv;
    assign ch1_data = c1_w.pix;
    assign ch1_fv   = c1_w.fv;
    assign ch1_lv   = c1_w.lv;
    assign ovf0     = l_ovf[0];
    assign ovf1     = l_ovf[1];

    assert_ovf0_sticky_R7: assert property (@(posedge sys_clk) disable iff (rst)
        ovf0 |=> ovf0);
endmodule

// File: tb/dlm_dual_link_tb.sv
module dlm_dual_link_tb;

    logic        sys_clk = 0, lk0 = 0, lk1 = 0;
    logic        rst = 1, fused_mode = 1;
    logic [23:0] d0 = '0, d1 = '0;
    logic        fv0 = 0, lv0 = 0, dv0 = 0, fv1 = 0, lv1 = 0, dv1 = 0;
    logic        m_valid, m_fv, m_lv, ch0_valid, ch0_fv, ch0_lv, ch1_valid, ch1_fv, ch1_lv;
    logic [47:0] m_data;
    logic [23:0] ch0_data, ch1_data;
    logic        align_err, ovf0, ovf1;

    always #4 sys_clk = ~sys_clk;
    always #5 lk0     = ~lk0;
    always #6 lk1     = ~lk1;

    dlm_dual_link u_dut (
        .sys_clk(sys_clk), .rst(rst), .fused_mode(fused_mode),
        .lnk0_clk(lk0), .lnk0_data(d0), .lnk0_fv(fv0), .lnk0_lv(lv0), .lnk0_dv(dv0),
        .lnk1_clk(lk1), .lnk1_data(d1), .lnk1_fv(fv1), .lnk1_lv(lv1), .lnk1_dv(dv1),
        .m_valid(m_valid), .m_data(m_data), .m_fv(m_fv), .m_lv(m_lv),
        .ch0_valid(ch0_valid), .ch0_data(ch0_data), .ch0_fv(ch0_fv), .ch0_lv(ch0_lv),
        .ch1_valid(ch1_valid), .ch1_data(ch1_data), .ch1_fv(ch1_fv), .ch1_lv(ch1_lv),
        .align_err(align_err), .ovf0(ovf0), .ovf1(ovf1)
    );

    localparam int NTAB = 8;
    localparam logic [23:0] TAB0 [NTAB] = '{24'h000A01, 24'h123456, 24'hFFFFFF, 24'h000000,
                                            24'h5A5A5A, 24'hA5A5A5, 24'h0F0F0F, 24'h800001};
    localparam logic [23:0] TAB1 [NTAB] = '{24'h100B02, 24'h654321, 24'h000000, 24'hFFFFFF,
                                            24'hC3C3C3, 24'h3C3C3C, 24'hF0F0F0, 24'h7FFFFE};

    int errors = 0, checks = 0;
    logic [49:0] m_log  [32];
    logic [25:0] c0_log [32];
    logic [25:0] c1_log [32];
    int m_n = 0, c0_n = 0, c1_n = 0;

    always @(negedge sys_clk) begin
        if (!rst) begin
            if (m_valid && m_n < 32)     begin m_log[m_n]   = {m_fv, m_lv, m_data};       m_n++;  end
            if (ch0_valid && c0_n < 32)  begin c0_log[c0_n] = {ch0_fv, ch0_lv, ch0_data}; c0_n++; end
            if (ch1_valid && c1_n < 32)  begin c1_log[c1_n] = {ch1_fv, ch1_lv, ch1_data}; c1_n++; end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        m_n = 0; c0_n = 0; c1_n = 0;
    endtask

    task automatic w0(input logic [23:0] d, input logic f, input logic l);
        @(negedge lk0); d0 = d; fv0 = f; lv0 = l; dv0 = 1;
    endtask
    task automatic i0();
        @(negedge lk0); dv0 = 0; lv0 = 0; fv0 = 0;
    endtask
    task automatic w1(input logic [23:0] d, input logic f, input logic l);
        @(negedge lk1); d1 = d; fv1 = f; lv1 = l; dv1 = 1;
    endtask
    task automatic i1();
        @(negedge lk1); dv1 = 0; lv1 = 0; fv1 = 0;
    endtask

    task automatic settle();
        repeat (60) @(posedge sys_clk);
    endtask

    task automatic do_reset(input logic mode);
        rst = 1; fused_mode = mode;
        repeat (8) @(posedge sys_clk);
        @(negedge sys_clk);
        chk(!m_valid && !ch0_valid && !ch1_valid, "R8 valids in reset", {m_valid, ch0_valid, ch1_valid}, 0);
        rst = 0;
        repeat (4) @(posedge sys_clk);
        @(negedge sys_clk);
        chk(!align_err && !ovf0 && !ovf1, "R8 flags after reset", {align_err, ovf0, ovf1}, 0);
        chk(!m_valid && !ch0_valid && !ch1_valid, "R8 valids after reset", {m_valid, ch0_valid, ch1_valid}, 0);
        clear_logs();
    endtask

    task automatic run_tests();
        // ---- fused mode, table-driven line with skew and leading junk (R3 R4 R5)
        do_reset(1'b1);
        fork
            begin
                w0(24'hDEAD01, 0, 0); w0(24'hDEAD02, 0, 0); i0();
                for (int i = 0; i < NTAB; i++) w0(TAB0[i], 1, 1);
                i0();
            end
            begin
                repeat (3) @(negedge lk1);
                for (int i = 0; i < NTAB; i++) w1(TAB1[i], 1, 1);
                i1();
            end
        join
        settle();
        chk(m_n == NTAB, "R4 merged count after junk", m_n, NTAB);
        for (int i = 0; i < NTAB; i++) begin
            chk(m_log[i] == {1'b1, 1'b1, TAB1[i], TAB0[i]}, "R3 R5 merged word",
                m_log[i], {1'b1, 1'b1, TAB1[i], TAB0[i]});
        end
        chk(c0_n == 0 && c1_n == 0, "R2 channels quiet in fused", {c0_n, c1_n}, 0);
        chk(!align_err, "R6 no error on clean line", align_err, 0);

        // ---- mismatch then recovery (R6)
        clear_logs();
        fork
            begin
                for (int i = 0; i < 4; i++) w0(24'h300000 + 24'(i), 1, 1);
                i0();
            end
            begin
                w1(24'h400000, 1, 1); w1(24'h400001, 1, 1);
                w1(24'h400002, 1, 0); w1(24'h400003, 1, 0); i1();
            end
        join
        settle();
        chk(align_err, "R6 error set on mismatch", align_err, 1);
        chk(m_n == 2, "R6 mismatched pair discarded", m_n, 2);
        clear_logs();
        fork
            begin for (int i = 0; i < 4; i++) w0(24'h500000 + 24'(i), 1, 1); i0(); end
            begin for (int i = 0; i < 4; i++) w1(24'h600000 + 24'(i), 1, 1); i1(); end
        join
        settle();
        chk(m_n == 4, "R6 realigned count", m_n, 4);
        chk(m_log[0] == {2'b11, 24'h600000, 24'h500000}, "R6 realigned first word",
            m_log[0], {2'b11, 24'h600000, 24'h500000});
        chk(align_err, "R6 error stays sticky", align_err, 1);

        // ---- overflow on link 0 (R7)
        clear_logs();
        for (int i = 0; i < 12; i++) w0(24'hA00000 + 24'(i), 1, 1);
        i0();
        settle();
        chk(ovf0 && !ovf1, "R7 overflow flags", {ovf0, ovf1}, 2'b10);
        chk(m_n == 0, "R7 nothing merged while link 1 idle", m_n, 0);
        for (int i = 0; i < 8; i++) w1(24'hB00000 + 24'(i), 1, 1);
        i1();
        settle();
        chk(m_n == 8, "R7 stored words kept", m_n, 8);
        for (int i = 0; i < 8; i++) begin
            chk(m_log[i][47:0] == {24'hB00000 + 24'(i), 24'hA00000 + 24'(i)}, "R7 no overwrite",
                m_log[i][47:0], {24'hB00000 + 24'(i), 24'hA00000 + 24'(i)});
        end
        chk(ovf0, "R7 overflow sticky", ovf0, 1);

        // ---- dual-camera mode (R1 R2)
        do_reset(1'b0);
        fork
            begin for (int i = 0; i < 3; i++) w0(24'hC00000 + 24'(i), 1, i[0]); i0(); end
            begin for (int i = 0; i < 5; i++) w1(24'hD00000 + 24'(i), 0, 1); i1(); end
        join
        settle();
        chk(c0_n == 3, "R1 channel 0 count", c0_n, 3);
        chk(c1_n == 5, "R1 channel 1 count", c1_n, 5);
        for (int i = 0; i < 3; i++)
            chk(c0_log[i] == {1'b1, i[0], 24'hC00000 + 24'(i)}, "R1 channel 0 word",
                c0_log[i], {1'b1, i[0], 24'hC00000 + 24'(i)});
        for (int i = 0; i < 5; i++)
            chk(c1_log[i] == {1'b0, 1'b1, 24'hD00000 + 24'(i)}, "R1 channel 1 word",
                c1_log[i], {1'b0, 1'b1, 24'hD00000 + 24'(i)});
        chk(m_n == 0, "R2 merged quiet in dual mode", m_n, 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge sys_clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule